// File: doc/BRIEF.md
# I/O Port Permission Checker

This block rules on whether an I/O port instruction (single or repeated string input and output) may go ahead. A caller presents the current privilege level, the 2-bit I/O privilege field, a flag saying whether the task uses the legacy or the extended task-state format, the port number, an access-width code, and the base and limit of the task's permission bitmap. The block answers with one response pulse carrying either allow or a general-protection fault with vector 13. The caller makes the check once for every I/O operation, including every iteration of a repeated string form.

The decision has two tiers. A privilege compare settles most requests in one cycle: a sufficiently privileged caller is allowed, and an under-privileged caller on a legacy-format task is faulted. Only an under-privileged caller on an extended-format task needs the bitmap. The block then reads two consecutive bitmap bytes through a byte read port with a valid/ready handshake and checks one bit per port byte touched. A set bit denies access.

States: `ST_IDLE` (ready for a request), `ST_READ0` (first bitmap byte), `ST_READ1` (following byte), `ST_DONE` (response pulse). Transitions: IDLE→DONE on an accepted request settled by the compare; IDLE→READ0 on an accepted request that needs the bitmap; READ0→READ1 on a read handshake or an out-of-limit address; READ1→DONE under the same condition; DONE→IDLE always.

Top module: `io_perm_check`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, allow, fault and mem_rd_valid are 0.
- R2: A request with cpl numerically at or below iopl gets resp_valid with allow=1 in the cycle after acceptance, whatever the task format, and issues no bitmap read.
- R3: A request with cpl above iopl on a legacy-format task (ext_task=0) gets resp_valid with fault=1 in the cycle after acceptance and issues no bitmap read.
- R4: fault_vector is 13 whenever fault is 1. allow and fault are never both 1, and neither is 1 outside a resp_valid cycle.
- R5: A request with cpl above iopl on an extended-format task reads byte address bmap_base + port/8 first and then the next address, each held stable until mem_rd_ready.
- R6: Bit k of the bitmap byte at bmap_base + j covers port 8*j + k. A value of 1 denies and 0 permits. The request is allowed only if every port from port to port + width - 1 has a clear bit.
- R7: A bitmap byte address above bmap_limit is never read and counts as all bits set (denied).
- R8: req_ready is 1 only in ST_IDLE. For a bitmap lookup whose two bytes are both in range, resp_valid rises in the cycle after the second read handshake. resp_valid lasts one cycle and is followed by ST_IDLE.
- R9: width_code 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege field |
| ext_task | input | 1 | 1 = extended task-state format, 0 = legacy |
| port | input | PORT_W | I/O port number |
| width_code | input | 2 | Access width code (R9) |
| bmap_base | input | ADDR_W | Byte address of bitmap start |
| bmap_limit | input | ADDR_W | Highest valid bitmap byte address |
| mem_rd_valid | output | 1 | Bitmap read request |
| mem_rd_ready | input | 1 | Read data present this cycle |
| mem_rd_addr | output | ADDR_W | Bitmap byte address |
| mem_rd_data | input | 8 | Bitmap byte |
| resp_valid | output | 1 | Response pulse |
| allow | output | 1 | Access granted |
| fault | output | 1 | General-protection fault |
| fault_vector | output | 8 | 13 when fault, else 0 |

## Verification
Requests settled by the compare must respond in the cycle right after the accepting edge. The bench drives each request at a falling edge and reads the response at the next falling edge, so that latency is exact. A bitmap response is due one cycle after the second read handshake. The bench's memory model stamps each handshake with a cycle count and compares the response's stamp with it, across read latencies of zero to two wait cycles. Every verdict is compared with a value the bench computes bit by bit from its own copy of the bitmap and the limit, over every port of the covered range and every width.

// File: rtl/iopc_pkg.sv
package iopc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ0 = 2'd1,
        ST_READ1 = 2'd2,
        ST_DONE  = 2'd3
    } iopc_state_e;

    localparam logic [7:0] GP_VECTOR = 8'd13;
    localparam int unsigned SPAN_MAX = 4;

    function automatic logic [2:0] span_of(input logic [1:0] code);
        unique case (code)
            2'd0:    span_of = 3'd1;
            2'd1:    span_of = 3'd2;
            default: span_of = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/iopc_priv_cmp.sv
module iopc_priv_cmp #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] cur_level,
    input  logic [PL_W-1:0] io_level,
    output logic            level_ok
);
    // lower number means more trusted
    assign level_ok = (cur_level <= io_level);
endmodule

// File: rtl/iopc_bit_window.sv
module iopc_bit_window
    import iopc_pkg::*;
(
    input  logic [15:0] window,
    input  logic [2:0]  bit_off,
    input  logic [1:0]  code,
    output logic        denied
);
    logic [2:0]          span;
    logic [SPAN_MAX-1:0] hit;

    assign span = span_of(code);

    for (genvar k = 0; k < SPAN_MAX; k++) begin : g_lane
        logic [3:0] idx;
        assign idx    = {1'b0, bit_off} + 4'(k);
        assign hit[k] = (3'(k) < span) && window[idx];
    end

    assign denied = |hit;
endmodule

// File: rtl/io_perm_check.sv
module io_perm_check
    import iopc_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        cpl,
    input  logic [1:0]        iopl,
    input  logic              ext_task,
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        width_code,
    input  logic [ADDR_W-1:0] bmap_base,
    input  logic [ADDR_W-1:0] bmap_limit,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              resp_valid,
    output logic              allow,
    output logic              fault,
    output logic [7:0]        fault_vector
);
    localparam int XA_W = ADDR_W + 1;

    iopc_state_e state_q, state_d;

    logic [PORT_W-1:0] port_q;
    logic [1:0]        code_q;
    logic [ADDR_W-1:0] base_q, limit_q;
    logic              priv_ok_q, use_map_q;
    logic [7:0]        byte0_q, byte1_q;

    logic              level_ok;
    logic              req_fire;
    logic [XA_W-1:0]   addr0, addr_sel;
    logic              in_range, hs, step;
    logic              map_denied, grant;

    iopc_priv_cmp #(.PL_W(2)) u_cmp (
        .cur_level (cpl),
        .io_level  (iopl),
        .level_ok  (level_ok)
    );

    iopc_bit_window u_win (
        .window  ({byte1_q, byte0_q}),
        .bit_off (port_q[2:0]),
        .code    (code_q),
        .denied  (map_denied)
    );

    assign req_fire = req_valid && (state_q == ST_IDLE);
    assign addr0    = {1'b0, base_q} + XA_W'(port_q >> 3);
    assign addr_sel = (state_q == ST_READ1) ? addr0 + XA_W'(1) : addr0;
    assign in_range = addr_sel <= {1'b0, limit_q};
    assign hs       = mem_rd_valid && mem_rd_ready;
    assign step     = !in_range || hs;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_fire) state_d = (level_ok || !ext_task) ? ST_DONE : ST_READ0;
            ST_READ0: if (step)     state_d = ST_READ1;
            ST_READ1: if (step)     state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q    <= '0;
            code_q    <= '0;
            base_q    <= '0;
            limit_q   <= '0;
            priv_ok_q <= 1'b0;
            use_map_q <= 1'b0;
            byte0_q   <= '1;
            byte1_q   <= '1;
        end else begin
            if (req_fire) begin
                port_q    <= port;
                code_q    <= width_code;
                base_q    <= bmap_base;
                limit_q   <= bmap_limit;
                priv_ok_q <= level_ok;
                use_map_q <= !level_ok && ext_task;
                byte0_q   <= '1;
                byte1_q   <= '1;
            end
            if (state_q == ST_READ0 && hs) byte0_q <= mem_rd_data;
            if (state_q == ST_READ1 && hs) byte1_q <= mem_rd_data;
        end
    end

    assign grant = priv_ok_q || (use_map_q && !map_denied);

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_READ0 || state_q == ST_READ1) && in_range;
        mem_rd_addr  = addr_sel[ADDR_W-1:0];
        resp_valid   = (state_q == ST_DONE);
        allow        = resp_valid && grant;
        fault        = resp_valid && !grant;
        fault_vector = fault ? GP_VECTOR : 8'd0;
    end
endmodule

// File: rtl/iopc_checker.sv
module iopc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        cpl,
    input logic [1:0]        iopl,
    input logic              ext_task,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              resp_valid,
    input logic              allow,
    input logic              fault,
    input logic [7:0]        fault_vector
);
    p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_vector == 8'd13);

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (allow || fault) |-> (resp_valid && !(allow && fault)));

    p_fast_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cpl <= iopl) |=> (resp_valid && allow));

    p_legacy_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cpl > iopl && !ext_task) |=> (resp_valid && fault));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !resp_valid));

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
endmodule

bind io_perm_check iopc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .cpl          (cpl),
    .iopl         (iopl),
    .ext_task     (ext_task),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .resp_valid   (resp_valid),
    .allow        (allow),
    .fault        (fault),
    .fault_vector (fault_vector)
);

// File: tb/tb_io_perm_check.sv
module tb_io_perm_check;
    localparam int PORT_W = 16;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] BASE = 16'h0040;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        cpl = '0, iopl = '0;
    logic              ext_task = 1'b0;
    logic [PORT_W-1:0] port = '0;
    logic [1:0]        width_code = '0;
    logic [ADDR_W-1:0] bmap_base = BASE, bmap_limit = BASE;
    logic              mem_rd_valid, mem_rd_ready;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data;
    logic              resp_valid, allow, fault;
    logic [7:0]        fault_vector;

    io_perm_check #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) dut (.*);

    always #5 clk = ~clk;

    logic [7:0]  bmap [16];
    int          wait_cnt = 0;
    int          mem_lat = 0;
    int          cyc = 0;
    int          log_n = 0;
    logic [ADDR_W-1:0] log_addr [2048];
    int          log_cyc [2048];
    int          n_checks = 0, n_fail = 0;

    assign mem_rd_data  = (mem_rd_addr >= BASE && mem_rd_addr < BASE + 16) ?
                          bmap[4'(mem_rd_addr - BASE)] : 8'hA5;
    assign mem_rd_ready = mem_rd_valid && (wait_cnt == 0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_valid && mem_rd_ready) begin
            log_addr[log_n] <= mem_rd_addr;
            log_cyc[log_n]  <= cyc;
            log_n           <= log_n + 1;
            wait_cnt        <= mem_lat;
        end else if (mem_rd_valid) begin
            wait_cnt <= wait_cnt - 1;
        end else begin
            wait_cnt <= mem_lat;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_allow(input int p, input int code, input int lim);
        int span = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        for (int i = 0; i < span; i++) begin
            int b = p + i;
            if (int'(BASE) + b / 8 > lim) return 1'b0;
            if (bmap[b / 8][b % 8]) return 1'b0;
        end
        return 1'b1;
    endfunction

    int r_lat, r_allow, r_fault, r_vec, r_cyc, r_start, r_busy_ready;

    task automatic issue(input int c, input int io, input bit ext, input int p, input int code);
        @(negedge clk);
        cpl = 2'(c); iopl = 2'(io); ext_task = ext;
        port = PORT_W'(p); width_code = 2'(code);
        req_valid = 1'b1;
        r_start = log_n;
        @(negedge clk);
        req_valid = 1'b0;
        r_busy_ready = int'(req_ready);
        r_lat = 1;
        while (!resp_valid && r_lat < 60) begin
            @(negedge clk);
            r_lat++;
        end
        r_allow = int'(allow); r_fault = int'(fault);
        r_vec = int'(fault_vector); r_cyc = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) bmap[i] = 8'((i * 8'h5B) ^ 8'h24 ^ (i << 5));
        bmap[0] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && !resp_valid && !allow && !fault && !mem_rd_valid,
              "R1 reset outputs", int'({req_ready, resp_valid, allow, fault, mem_rd_valid}), 16);
        rst_n = 1'b1;

        // R2/R3/R4 fast tier, every level combination and both formats
        bmap_limit = BASE + 8;
        for (int c = 0; c < 4; c++)
            for (int io = 0; io < 4; io++)
                for (int e = 0; e < 2; e++) begin
                    int st;
                    issue(c, io, e[0], 9, 0);
                    st = log_n - r_start;
                    if (c <= io) begin
                        check(r_lat == 1 && r_allow == 1 && r_fault == 0, "R2 fast allow", r_lat * 10 + r_allow, 11);
                        check(st == 0, "R2 no read", st, 0);
                    end else if (e == 0) begin
                        check(r_lat == 1 && r_fault == 1 && r_allow == 0, "R3 legacy fault", r_lat * 10 + r_fault, 11);
                        check(r_vec == 13, "R4 vector", r_vec, 13);
                        check(st == 0, "R3 no read", st, 0);
                    end
                end

        // R5/R6/R8/R9 bitmap sweep, all bytes in range
        for (int p = 0; p < 64; p++)
            for (int code = 0; code < 4; code++) begin
                bit ex;
                mem_lat = (p + code) % 3;
                issue(3, 1, 1'b1, p, code);
                ex = exp_allow(p, code, int'(bmap_limit));
                check(r_allow == int'(ex) && r_fault == int'(!ex), "R6 R9 verdict", r_allow, int'(ex));
                if (!ex) check(r_vec == 13, "R4 vector map", r_vec, 13);
                check(r_busy_ready == 0, "R8 not ready while busy", r_busy_ready, 0);
                check(log_n - r_start == 2, "R5 read count", log_n - r_start, 2);
                check(int'(log_addr[r_start]) == int'(BASE) + p / 8 &&
                      int'(log_addr[r_start + 1]) == int'(BASE) + p / 8 + 1,
                      "R5 read order", int'(log_addr[r_start]), int'(BASE) + p / 8);
                check(r_cyc == log_cyc[r_start + 1] + 1, "R8 latency", r_cyc, log_cyc[r_start + 1] + 1);
            end

        // R7 limit: bytes beyond BASE+3 are denied and never read
        bmap_limit = BASE + 3;
        for (int p = 16; p < 48; p++)
            for (int code = 0; code < 3; code++) begin
                bit ex;
                int exp_n;
                mem_lat = p % 2;
                issue(2, 0, 1'b1, p, code);
                ex = exp_allow(p, code, int'(bmap_limit));
                exp_n = ((p / 8 <= 3) ? 1 : 0) + ((p / 8 + 1 <= 3) ? 1 : 0);
                check(r_allow == int'(ex) && r_fault == int'(!ex), "R7 R6 verdict", r_allow, int'(ex));
                check(log_n - r_start == exp_n, "R7 reads", log_n - r_start, exp_n);
            end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule